// File: doc/BRIEF.md
# CAN Message Buffer Status Sequencer

This block keeps the status word of a single CAN message buffer and steps its 4-bit state code through the receive and transmit life cycles. Software writes the status word. The rest of the controller reports events to the block as one-cycle pulses: an acceptance-filter hit, the end of a data copy, a transmit grant, a completed or lost transmission, and a matching remote frame on the bus. The block returns the status word, a transmit request with the buffer's priority for the arbiter between buffers, and a strobe that starts a data copy into the buffer.

On the receive side the block tracks a first copy, a second copy that leaves the buffer in an overrun state, and later copies while it is overrun. Software can cancel a copy that is in progress. On the transmit side the block sends one frame on request. It can also hold a frame as an automatic answer: it waits for a matching remote request and then sends the answer. When the buffer has sent its own remote request, it switches to receive-ready by itself so that it can collect the reply.

Top module: `can_mb_fsm`

## Requirements
- R1: While `rst` is high and in the cycle after it, `status_o` reads 0 (receive inactive, DLC 0, priority 0), and `tx_req_o` and `copy_en_o` are low.
- R2: Status word layout: bits 15:12 hold the DLC, bits 7:4 the priority and bits 3:0 the state code. All other bits read 0. In a non-busy state (even code), a write whose state code is even loads all three fields in the next cycle. A write with an odd state code is ignored. The state codes are: 0x0 receive off, 0x1 cancel pending, 0x2 receive armed, 0x3 first copy, 0x4 full, 0x5 second copy, 0x6 overrun, 0x7 overrun copy, 0x8 transmit off, 0xA auto-answer wait, 0xC send once, 0xD sending, 0xE send answer, 0xF sending answer.
- R3: In state 0x2, `acc_hit` moves the state to 0x3 and raises `copy_en_o` for exactly that one cycle. `copy_done` in 0x3 then moves the state to 0x4.
- R4: In state 0x4, `acc_hit` moves the state to 0x5 with a `copy_en_o` pulse, and `copy_done` then moves it to 0x6. In state 0x6, `acc_hit` moves the state to 0x7 with a pulse, and `copy_done` returns it to 0x6.
- R5: A write with state code 0x0 while a copy is running (0x3, 0x5, 0x7) changes only the state, to 0x1. A later `copy_done` then moves it to 0x0. If `copy_done` arrives in the same cycle as that write, the state goes straight to 0x0.
- R6: In every busy (odd) state, all other software writes are ignored: the DLC, priority and state stay as they were.
- R7: `tx_req_o` is high exactly while the state is 0xC or 0xE, and `tx_prio_o` carries the priority field. In 0xC, `tx_grant` moves the state to 0xD. In 0xD, `tx_lost` returns it to 0xC, and `tx_done` with `rtr_bit` low moves it to 0x8.
- R8: In 0xD, `tx_done` with `rtr_bit` high (the frame sent was a remote request) moves the state to 0x2.
- R9: In 0xA, `rtr_match` moves the state to 0xE.
- R10: In 0xE, `tx_grant` moves the state to 0xF. In 0xF, `tx_done` moves it to 0xA and `tx_lost` returns it to 0xE.
- R11: When a hardware event changes a non-busy state in some cycle, a software write in the same cycle is dropped. In 0xD or 0xF, `tx_done` takes precedence over `tx_lost`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe for the status word |
| wr_data | input | 16 | Status word to write (DLC, priority, state code) |
| acc_hit | input | 1 | Received frame passed this buffer's acceptance filter |
| copy_done | input | 1 | Data copy into the buffer finished |
| tx_grant | input | 1 | Arbiter selected this buffer for transmission |
| tx_done | input | 1 | Transmission finished successfully |
| tx_lost | input | 1 | Transmission lost bus arbitration |
| rtr_match | input | 1 | A remote request matching this buffer's identifier was received |
| rtr_bit | input | 1 | The buffer's own frame has its remote-request bit set |
| status_o | output | 16 | Status word |
| tx_req_o | output | 1 | Transmit request to the arbiter |
| tx_prio_o | output | 4 | Priority that goes with the request |
| copy_en_o | output | 1 | One-cycle strobe that starts a data copy |

## Verification
The bench targets a cancel request that lands in the same cycle as `copy_done`; a design that ignores the coincidence leaves the buffer stuck in the cancel-pending state. It sends writes during busy states; a design that accepts them corrupts the priority or the DLC of a frame in flight. It raises `tx_done` and `tx_lost` together, where the wrong choice retransmits a frame that was already sent. It also finishes a remote request with `rtr_bit` high, where a wrong design goes back to transmit-off and misses the reply. Last, it gives an acceptance hit and a write in the same cycle, where a design that takes the write drops a frame that is already being copied.

// File: rtl/can_mb_pkg.sv
package can_mb_pkg;

  localparam int ST_W = 4;

  // State codes; the low bit marks a busy state, odd codes 9 and B are unused
  localparam logic [ST_W-1:0] RX_OFF       = 4'h0;
  localparam logic [ST_W-1:0] RX_CANCEL    = 4'h1;
  localparam logic [ST_W-1:0] RX_ARMED     = 4'h2;
  localparam logic [ST_W-1:0] RX_COPY1     = 4'h3;
  localparam logic [ST_W-1:0] RX_HELD      = 4'h4;
  localparam logic [ST_W-1:0] RX_COPY2     = 4'h5;
  localparam logic [ST_W-1:0] RX_OVR       = 4'h6;
  localparam logic [ST_W-1:0] RX_COPY3     = 4'h7;
  localparam logic [ST_W-1:0] TX_OFF       = 4'h8;
  localparam logic [ST_W-1:0] TX_WAIT_REQ  = 4'hA;
  localparam logic [ST_W-1:0] TX_ONE       = 4'hC;
  localparam logic [ST_W-1:0] TX_SEND      = 4'hD;
  localparam logic [ST_W-1:0] TX_ANSWER    = 4'hE;
  localparam logic [ST_W-1:0] TX_SEND_ANS  = 4'hF;

  function automatic logic st_busy(input logic [ST_W-1:0] s);
    return s[0];
  endfunction

  function automatic logic st_copying(input logic [ST_W-1:0] s);
    return (s == RX_COPY1) || (s == RX_COPY2) || (s == RX_COPY3);
  endfunction

  function automatic logic st_requesting(input logic [ST_W-1:0] s);
    return (s == TX_ONE) || (s == TX_ANSWER);
  endfunction

endpackage

// File: rtl/can_mb_wr_gate.sv
module can_mb_wr_gate
  import can_mb_pkg::*;
(
  input  logic [ST_W-1:0] cur_st,
  input  logic            wr_en,
  input  logic [ST_W-1:0] wr_code,
  output logic            load_word,
  output logic            cancel_req
);

  always_comb begin
    load_word  = wr_en && !st_busy(cur_st) && !wr_code[0];
    cancel_req = wr_en && st_copying(cur_st) && (wr_code == RX_OFF);
  end

endmodule

// File: rtl/can_mb_next.sv
module can_mb_next
  import can_mb_pkg::*;
(
  input  logic [ST_W-1:0] cur_st,
  input  logic            acc_hit,
  input  logic            copy_done,
  input  logic            tx_grant,
  input  logic            tx_done,
  input  logic            tx_lost,
  input  logic            rtr_match,
  input  logic            rtr_bit,
  input  logic            cancel_req,
  output logic [ST_W-1:0] hw_st,
  output logic            hw_move,
  output logic            copy_start
);

  always_comb begin
    hw_st      = cur_st;
    hw_move    = 1'b0;
    copy_start = 1'b0;
    case (cur_st)
      RX_ARMED, RX_HELD, RX_OVR: begin
        if (acc_hit) begin
          hw_move    = 1'b1;
          copy_start = 1'b1;
          hw_st      = (cur_st == RX_ARMED) ? RX_COPY1 :
                       (cur_st == RX_HELD)  ? RX_COPY2 : RX_COPY3;
        end
      end
      RX_COPY1, RX_COPY2, RX_COPY3: begin
        if (cancel_req) begin
          hw_move = 1'b1;
          hw_st   = copy_done ? RX_OFF : RX_CANCEL;
        end else if (copy_done) begin
          hw_move = 1'b1;
          hw_st   = (cur_st == RX_COPY1) ? RX_HELD : RX_OVR;
        end
      end
      RX_CANCEL: begin
        if (copy_done) begin
          hw_move = 1'b1;
          hw_st   = RX_OFF;
        end
      end
      TX_ONE: begin
        if (tx_grant) begin
          hw_move = 1'b1;
          hw_st   = TX_SEND;
        end
      end
      TX_ANSWER: begin
        if (tx_grant) begin
          hw_move = 1'b1;
          hw_st   = TX_SEND_ANS;
        end
      end
      TX_SEND: begin
        if (tx_done) begin
          hw_move = 1'b1;
          hw_st   = rtr_bit ? RX_ARMED : TX_OFF;
        end else if (tx_lost) begin
          hw_move = 1'b1;
          hw_st   = TX_ONE;
        end
      end
      TX_SEND_ANS: begin
        if (tx_done) begin
          hw_move = 1'b1;
          hw_st   = TX_WAIT_REQ;
        end else if (tx_lost) begin
          hw_move = 1'b1;
          hw_st   = TX_ANSWER;
        end
      end
      TX_WAIT_REQ: begin
        if (rtr_match) begin
          hw_move = 1'b1;
          hw_st   = TX_ANSWER;
        end
      end
      default: begin
        hw_st = cur_st;
      end
    endcase
  end

endmodule

// File: rtl/can_mb_fsm.sv
module can_mb_fsm
  import can_mb_pkg::*;
#(
  parameter int DLC_W  = 4,
  parameter int PRIO_W = 4,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              acc_hit,
  input  logic              copy_done,
  input  logic              tx_grant,
  input  logic              tx_done,
  input  logic              tx_lost,
  input  logic              rtr_match,
  input  logic              rtr_bit,
  output logic [WORD_W-1:0] status_o,
  output logic              tx_req_o,
  output logic [PRIO_W-1:0] tx_prio_o,
  output logic              copy_en_o
);

  localparam int DLC_LSB  = WORD_W - DLC_W;
  localparam int PRIO_LSB = ST_W;
  localparam int PAD_LSB  = PRIO_LSB + PRIO_W;

  logic [ST_W-1:0]   st_q, st_d;
  logic [DLC_W-1:0]  dlc_q, dlc_d;
  logic [PRIO_W-1:0] prio_q, prio_d;
  logic              req_q, copy_q;

  logic              load_word, cancel_req;
  logic [ST_W-1:0]   hw_st;
  logic              hw_move, copy_start;
  logic              unused_wr_pad;

  assign unused_wr_pad = ^wr_data[DLC_LSB-1:PAD_LSB];

  can_mb_wr_gate u_gate (
    .cur_st     (st_q),
    .wr_en      (wr_en),
    .wr_code    (wr_data[ST_W-1:0]),
    .load_word  (load_word),
    .cancel_req (cancel_req)
  );

  can_mb_next u_next (
    .cur_st     (st_q),
    .acc_hit    (acc_hit),
    .copy_done  (copy_done),
    .tx_grant   (tx_grant),
    .tx_done    (tx_done),
    .tx_lost    (tx_lost),
    .rtr_match  (rtr_match),
    .rtr_bit    (rtr_bit),
    .cancel_req (cancel_req),
    .hw_st      (hw_st),
    .hw_move    (hw_move),
    .copy_start (copy_start)
  );

  // Hardware events win over a same-cycle software write
  always_comb begin
    st_d   = st_q;
    dlc_d  = dlc_q;
    prio_d = prio_q;
    if (hw_move) begin
      st_d = hw_st;
    end else if (load_word) begin
      st_d   = wr_data[ST_W-1:0];
      dlc_d  = wr_data[DLC_LSB +: DLC_W];
      prio_d = wr_data[PRIO_LSB +: PRIO_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= RX_OFF;
      dlc_q  <= '0;
      prio_q <= '0;
      req_q  <= 1'b0;
      copy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      dlc_q  <= dlc_d;
      prio_q <= prio_d;
      req_q  <= st_requesting(st_d);
      copy_q <= copy_start;
    end
  end

  always_comb begin
    status_o                       = '0;
    status_o[ST_W-1:0]             = st_q;
    status_o[PRIO_LSB +: PRIO_W]   = prio_q;
    status_o[DLC_LSB +: DLC_W]     = dlc_q;
  end

  assign tx_req_o  = req_q;
  assign tx_prio_o = prio_q;
  assign copy_en_o = copy_q;

endmodule

// File: rtl/can_mb_fsm_chk.sv
module can_mb_fsm_chk
  import can_mb_pkg::*;
#(
  parameter int PRIO_W = 4,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic              acc_hit,
  input logic              copy_done,
  input logic              tx_grant,
  input logic              tx_done,
  input logic              tx_lost,
  input logic              rtr_match,
  input logic [WORD_W-1:0] status_o,
  input logic              tx_req_o,
  input logic              copy_en_o
);

  logic [ST_W-1:0] st;
  assign st = status_o[ST_W-1:0];

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (status_o == '0 && !tx_req_o && !copy_en_o));

  assert_first_copy_R3: assert property (@(posedge clk) disable iff (rst)
    (st == RX_ARMED && acc_hit) |=> (st == RX_COPY1 && copy_en_o));

  assert_strobe_in_copy_R3: assert property (@(posedge clk) disable iff (rst)
    copy_en_o |-> st_copying(st));

  assert_overrun_R4: assert property (@(posedge clk) disable iff (rst)
    (st == RX_COPY2 && copy_done) |=> (st == RX_OVR || st == RX_OFF));

  assert_cancel_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (st == RX_CANCEL && !copy_done) |=> st == RX_CANCEL);

  assert_busy_locked_R6: assert property (@(posedge clk) disable iff (rst)
    (st == TX_SEND && !tx_done && !tx_lost) |=> $stable(status_o));

  assert_req_matches_R7: assert property (@(posedge clk) disable iff (rst)
    tx_req_o == st_requesting(st));

  assert_remote_seen_R9: assert property (@(posedge clk) disable iff (rst)
    (st == TX_WAIT_REQ && rtr_match) |=> st == TX_ANSWER);

  assert_answer_sent_R10: assert property (@(posedge clk) disable iff (rst)
    (st == TX_SEND_ANS && tx_done) |=> st == TX_WAIT_REQ);

  assert_event_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (st == TX_ONE && tx_grant && wr_en) |=> st == TX_SEND);

  logic unused_chk;
  assign unused_chk = ^{wr_data, tx_lost};

endmodule

bind can_mb_fsm can_mb_fsm_chk #(.PRIO_W(PRIO_W), .WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .acc_hit   (acc_hit),
  .copy_done (copy_done),
  .tx_grant  (tx_grant),
  .tx_done   (tx_done),
  .tx_lost   (tx_lost),
  .rtr_match (rtr_match),
  .status_o  (status_o),
  .tx_req_o  (tx_req_o),
  .copy_en_o (copy_en_o)
);

// File: tb/can_mb_fsm_bench.sv
`timescale 1ns/1ps
module can_mb_fsm_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        acc_hit = 1'b0, copy_done = 1'b0, tx_grant = 1'b0, tx_done = 1'b0;
  logic        tx_lost = 1'b0, rtr_match = 1'b0, rtr_bit = 1'b0;
  logic [15:0] status_o;
  logic        tx_req_o, copy_en_o;
  logic [3:0]  tx_prio_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit armed = 0;

  // reference model state
  logic [3:0] m_st = '0, m_dlc = '0, m_prio = '0;
  logic       m_req = 1'b0, m_copy = 1'b0;
  string      m_tag = "R1";

  always #2.5 clk = ~clk;

  can_mb_fsm u_can_mb_fsm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .acc_hit(acc_hit), .copy_done(copy_done), .tx_grant(tx_grant),
    .tx_done(tx_done), .tx_lost(tx_lost), .rtr_match(rtr_match),
    .rtr_bit(rtr_bit), .status_o(status_o), .tx_req_o(tx_req_o),
    .tx_prio_o(tx_prio_o), .copy_en_o(copy_en_o)
  );

  function automatic logic [25:0] exp_vec();
    return {m_dlc, 4'h0, m_prio, m_st, m_req, m_prio, m_copy};
  endfunction

  task automatic compare();
    logic [25:0] act;
    act = {status_o, tx_req_o, tx_prio_o, copy_en_o};
    checks++;
    if (act !== exp_vec()) begin
      errors++;
      $display("FAIL %s status/req/prio/copy actual %h %b %h %b expected %h %b %h %b",
               m_tag, status_o, tx_req_o, tx_prio_o, copy_en_o,
               {m_dlc, 4'h0, m_prio, m_st}, m_req, m_prio, m_copy);
    end
  endtask

  // Expected next values, derived from the requirement list
  task automatic model(input logic r, input logic we, input logic [15:0] wd,
                       input logic hit, input logic cd, input logic gr,
                       input logic dn, input logic ls, input logic rm, input logic rb);
    logic [3:0] c, nx, code;
    logic mv;
    c = m_st; nx = c; code = wd[3:0]; mv = 1'b0;
    m_copy = 1'b0;
    if (r) begin
      m_st = '0; m_dlc = '0; m_prio = '0; m_req = 1'b0; m_tag = "R1";
      return;
    end
    m_tag = we ? "R6" : "R2";
    case (c)
      4'h2: if (hit) begin nx = 4'h3; mv = 1; m_copy = 1; m_tag = "R3"; end
      4'h4: if (hit) begin nx = 4'h5; mv = 1; m_copy = 1; m_tag = "R4"; end
      4'h6: if (hit) begin nx = 4'h7; mv = 1; m_copy = 1; m_tag = "R4"; end
      4'h3, 4'h5, 4'h7: begin
        if (we && code == 4'h0) begin nx = cd ? 4'h0 : 4'h1; mv = 1; m_tag = "R5"; end
        else if (cd) begin nx = (c == 4'h3) ? 4'h4 : 4'h6; mv = 1;
                           m_tag = (c == 4'h3) ? "R3" : "R4"; end
      end
      4'h1: if (cd) begin nx = 4'h0; mv = 1; m_tag = "R5"; end
      4'hC: if (gr) begin nx = 4'hD; mv = 1; m_tag = "R7"; end
      4'hE: if (gr) begin nx = 4'hF; mv = 1; m_tag = "R10"; end
      4'hD: begin
        if (dn) begin nx = rb ? 4'h2 : 4'h8; mv = 1; m_tag = ls ? "R11" : (rb ? "R8" : "R7"); end
        else if (ls) begin nx = 4'hC; mv = 1; m_tag = "R7"; end
      end
      4'hF: begin
        if (dn) begin nx = 4'hA; mv = 1; m_tag = ls ? "R11" : "R10"; end
        else if (ls) begin nx = 4'hE; mv = 1; m_tag = "R10"; end
      end
      4'hA: if (rm) begin nx = 4'hE; mv = 1; m_tag = "R9"; end
      default: ;
    endcase
    if (mv) begin
      if (we && !c[0]) m_tag = "R11";
      m_st = nx;
    end else if (we && !c[0]) begin
      m_tag = "R2";
      if (!code[0]) begin m_st = code; m_dlc = wd[15:12]; m_prio = wd[7:4]; end
    end
    m_req = (m_st == 4'hC) || (m_st == 4'hE);
  endtask

  // One cycle: check previous result at negedge, then drive and predict
  task automatic step(input logic r, input logic we, input logic [15:0] wd,
                      input logic [6:0] ev);
    @(negedge clk);
    if (armed) compare();
    rst = r; wr_en = we; wr_data = wd;
    {acc_hit, copy_done, tx_grant, tx_done, tx_lost, rtr_match, rtr_bit} = ev;
    model(r, we, wd, ev[6], ev[5], ev[4], ev[3], ev[2], ev[1], ev[0]);
    armed = 1;
  endtask

  localparam logic [6:0] E_NONE = 7'b0000000, E_HIT = 7'b1000000, E_CD = 7'b0100000,
                         E_GR = 7'b0010000, E_DN = 7'b0001000, E_LS = 7'b0000100,
                         E_RM = 7'b0000010, E_RB = 7'b0000001;

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // R1 reset
    step(1, 0, 16'h0, E_NONE);
    step(1, 0, 16'h0, E_NONE);
    step(0, 0, 16'h0, E_NONE);
    // R2 load, R3 first copy, R4 second and overrun copy, R6 ignored write, R5 cancel
    step(0, 1, 16'h5032, E_NONE);
    step(0, 0, 16'h0, E_HIT);
    step(0, 0, 16'h0, E_NONE);
    step(0, 0, 16'h0, E_CD);
    step(0, 0, 16'h0, E_HIT);
    step(0, 0, 16'h0, E_CD);
    step(0, 0, 16'h0, E_HIT);
    step(0, 1, 16'hF0F2, E_NONE);
    step(0, 1, 16'h0000, E_NONE);
    step(0, 1, 16'h0002, E_NONE);
    step(0, 0, 16'h0, E_CD);
    // R5 cancel and copy end in the same cycle
    step(0, 1, 16'h1002, E_NONE);
    step(0, 0, 16'h0, E_HIT);
    step(0, 1, 16'h0000, E_CD);
    // R7 send once with lost arbitration, R8 remote request sent
    step(0, 1, 16'h7A0C, E_NONE);
    step(0, 0, 16'h0, E_GR);
    step(0, 1, 16'h000C, E_NONE);
    step(0, 0, 16'h0, E_LS);
    step(0, 0, 16'h0, E_GR);
    step(0, 0, 16'h0, E_DN | E_RB);
    // R11 done beats lost
    step(0, 1, 16'h003C, E_NONE);
    step(0, 0, 16'h0, E_GR);
    step(0, 0, 16'h0, E_DN | E_LS);
    // R9, R10 automatic answer loop
    step(0, 1, 16'h205A, E_NONE);
    step(0, 0, 16'h0, E_GR);
    step(0, 0, 16'h0, E_RM);
    step(0, 0, 16'h0, E_GR);
    step(0, 0, 16'h0, E_LS);
    step(0, 0, 16'h0, E_GR);
    step(0, 0, 16'h0, E_DN);
    // R2 odd code ignored
    step(0, 1, 16'h0009, E_NONE);
    // R11 hit and write together
    step(0, 1, 16'h0002, E_NONE);
    step(0, 1, 16'h0004, E_HIT);
    step(0, 0, 16'h0, E_CD);
    // random mix
    for (int i = 0; i < 5000; i++) begin
      logic [6:0] ev;
      logic [15:0] wd;
      logic we, r;
      ev = '0;
      for (int k = 0; k < 7; k++) ev[k] = ($urandom % 3) == 0;
      wd = 16'($urandom);
      we = ($urandom % 5) == 0;
      r  = ($urandom % 700) == 0;
      step(r, we, wd, ev);
    end
    step(0, 0, 16'h0, E_NONE);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule